// File: doc/BRIEF.md
# Macro-Block Spatial Locality Prefetcher

This block sits beside an L1 data cache and watches the stream of demand-miss line addresses. Line addresses are grouped into aligned macro-blocks of four consecutive lines. A small tracking table holds, for each recently seen macro-block, a mask of which of its four lines have been demanded. When enough distinct lines of one macro-block have been demanded (two by default), the block queues prefetch requests for the remaining lines of that macro-block that have not been demanded.

Queued prefetch addresses wait in a short collapsing queue and leave one per handshake on the output, each labelled as a prefetch. A later demand for a line that still waits in the queue removes it there, because the demand already fetches that line. A macro-block fires its prefetches at most once while it stays in the table. The table replaces its entries in allocation order. When the queue is full, surplus prefetches are discarded.

Top module: `mb_prefetcher`

## Requirements
- R1: A line address L belongs to macro-block L>>2 and sits at offset L[1:0]. Lines of different macro-blocks never count toward one another, even when their addresses are adjacent.
- R2: `dem_ready` is 1 in every cycle after reset, so a demand is taken in any cycle where `dem_valid` is 1.
- R3: When a demand brings the number of distinct demanded lines of a tracked macro-block to THRESH (default 2), each undemanded line of that macro-block is queued in ascending offset order. The first one appears on `pf_line` with `pf_valid` high just after the clock edge that took the demand. A single demanded line queues nothing.
- R4: Repeated demands for the same line count once toward the threshold.
- R5: After a macro-block has fired, further demands to it queue nothing until its entry is replaced. This holds even if some of its prefetches were discarded.
- R6: Prefetches leave in the order they were queued, one per edge on which `pf_valid` and `pf_ready` are both 1. While `pf_ready` is 0, `pf_valid` and `pf_line` hold.
- R7: The queue holds DEPTH (default 4) addresses. Prefetches that find it full are discarded, and the queued ones are kept.
- R8: A demand for a line that waits in the queue removes that entry at the same edge, whether or not it is the head. The other entries keep their order.
- R9: The table holds ENTRIES (default 8) macro-blocks. A demand to an untracked macro-block overwrites the entry allocated longest ago, and that block's history is lost.
- R10: `pf_kind` is 1 (prefetch; 0 would mean demand) whenever `pf_valid` is 1.
- R11: After reset, `pf_valid` is 0 and the table is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dem_valid | input | 1 | A demand-miss line address is offered |
| dem_ready | output | 1 | The demand is accepted (always 1) |
| dem_line | input | LINE_W | Demanded cache-line address |
| pf_valid | output | 1 | A prefetch line address is offered |
| pf_ready | input | 1 | The consumer takes the prefetch |
| pf_line | output | LINE_W | Prefetch cache-line address |
| pf_kind | output | 1 | Request label: 1 prefetch, 0 demand |

## Verification
Every effect of a demand is due at the clock edge that takes it. A fire, a cancellation or a discard changes `pf_valid` and `pf_line` right after that edge, and a pop moves the head on at the edge where `pf_ready` is seen high. The bench drives inputs on the falling edge and samples half a cycle after each rising edge. A behavioural model built from queues and integer arrays applies the same rules at each rising edge. The outputs are compared with it after every edge, and directed sequences also check hand-worked values at those same sample points.

// File: rtl/mb_pf_pkg.sv
package mb_pf_pkg;
   localparam int MB_LINES = 4;
   localparam int MB_OFF_W = 2;
   typedef enum logic {
      REQ_DEMAND   = 1'b0,
      REQ_PREFETCH = 1'b1
   } req_kind_e;
endpackage

// File: rtl/mb_pf_table.sv
module mb_pf_table #(
   parameter int TAG_W   = 14,
   parameter int ENTRIES = 8,
   parameter int THRESH  = 2
) (
   input  logic                              clk,
   input  logic                              rst,
   input  logic                              dem_en,
   input  logic [TAG_W-1:0]                  dem_tag,
   input  logic [mb_pf_pkg::MB_OFF_W-1:0]    dem_off,
   output logic                              fire,
   output logic [TAG_W-1:0]                  fire_tag,
   output logic [mb_pf_pkg::MB_LINES-1:0]    fire_mask
);
   import mb_pf_pkg::*;
   localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

   initial begin
      assert (THRESH >= 1 && THRESH <= MB_LINES) else $error("THRESH out of range");
      assert (ENTRIES >= 1) else $error("ENTRIES must be positive");
   end

   logic [TAG_W-1:0]    tag_q  [ENTRIES];
   logic [MB_LINES-1:0] mask_q [ENTRIES];
   logic                vld_q  [ENTRIES];
   logic                done_q [ENTRIES];
   logic [IDX_W-1:0]    alloc_ptr;
   logic [ENTRIES-1:0]  hit_vec;

   logic                hit, cur_done;
   logic [IDX_W-1:0]    hit_idx, wr_idx;
   logic [MB_LINES-1:0] cur_mask, new_mask;

   for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
      assign hit_vec[e] = vld_q[e] && (tag_q[e] == dem_tag);
   end

   always_comb begin
      hit     = 1'b0;
      hit_idx = '0;
      for (int e = 0; e < ENTRIES; e++) begin
         if (hit_vec[e]) begin
            hit     = 1'b1;
            hit_idx = IDX_W'(e);
         end
      end
      cur_mask  = hit ? mask_q[hit_idx] : '0;
      cur_done  = hit ? done_q[hit_idx] : 1'b0;
      new_mask  = cur_mask | (MB_LINES'(1) << dem_off);
      fire      = dem_en && !cur_done && ($countones(new_mask) >= THRESH);
      fire_mask = ~new_mask;
      fire_tag  = dem_tag;
      wr_idx    = hit ? hit_idx : alloc_ptr;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         alloc_ptr <= '0;
         for (int e = 0; e < ENTRIES; e++) begin
            vld_q[e]  <= 1'b0;
            done_q[e] <= 1'b0;
         end
      end else if (dem_en) begin
         tag_q[wr_idx]  <= dem_tag;
         mask_q[wr_idx] <= new_mask;
         vld_q[wr_idx]  <= 1'b1;
         done_q[wr_idx] <= cur_done | fire;
         if (!hit)
            alloc_ptr <= (alloc_ptr == IDX_W'(ENTRIES - 1)) ? '0 : alloc_ptr + 1'b1;
      end
   end

   // R3: a firing block has exactly THRESH demanded lines
   a_r3_fire_count: assert property (@(posedge clk) disable iff (rst)
      fire |-> ($countones(fire_mask) == MB_LINES - THRESH));

   // R4: the demanded line is never among its own prefetches
   a_r4_skip_demanded: assert property (@(posedge clk) disable iff (rst)
      fire |-> !fire_mask[dem_off]);

   // R5: a block that just fired does not fire again on the next demand to it
   a_r5_fire_once: assert property (@(posedge clk) disable iff (rst)
      fire |=> !(dem_en && dem_tag == $past(dem_tag) && fire));
endmodule

// File: rtl/mb_pf_queue.sv
module mb_pf_queue #(
   parameter int LINE_W = 16,
   parameter int DEPTH  = 4
) (
   input  logic                           clk,
   input  logic                           rst,
   input  logic                           pop,
   input  logic                           cancel_en,
   input  logic [LINE_W-1:0]              cancel_line,
   input  logic [mb_pf_pkg::MB_LINES-1:0] push_mask,
   input  logic [LINE_W-3:0]              push_tag,
   output logic                           head_valid,
   output logic [LINE_W-1:0]              head_line
);
   import mb_pf_pkg::*;
   localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   initial begin
      assert (DEPTH >= 1) else $error("DEPTH must be positive");
   end

   logic [LINE_W-1:0] ql_q [DEPTH];
   logic              qv_q [DEPTH];
   logic [LINE_W-1:0] nl   [DEPTH];
   logic              nv   [DEPTH];

   always_comb begin
      int n;
      n = 0;
      for (int i = 0; i < DEPTH; i++) begin
         nl[i] = ql_q[i];
         nv[i] = 1'b0;
      end
      for (int i = 0; i < DEPTH; i++) begin
         if (qv_q[i] && !(pop && i == 0) &&
             !(cancel_en && ql_q[i] == cancel_line)) begin
            nl[IW'(n)] = ql_q[i];
            nv[IW'(n)] = 1'b1;
            n = n + 1;
         end
      end
      for (int j = 0; j < MB_LINES; j++) begin
         if (push_mask[j] && n < DEPTH) begin
            nl[IW'(n)] = {push_tag, MB_OFF_W'(j)};
            nv[IW'(n)] = 1'b1;
            n = n + 1;
         end
      end
   end

   always_ff @(posedge clk) begin
      for (int i = 0; i < DEPTH; i++) begin
         ql_q[i] <= nl[i];
         qv_q[i] <= rst ? 1'b0 : nv[i];
      end
   end

   assign head_valid = qv_q[0];
   assign head_line  = ql_q[0];

   // R6: a stalled head that is not cancelled holds
   a_r6_hold_stall: assert property (@(posedge clk) disable iff (rst)
      (head_valid && !pop && !(cancel_en && cancel_line == head_line))
      |=> (head_valid && head_line == $past(head_line)));

   // R8: a cancelled line is not at the head afterwards
   a_r8_cancel_gone: assert property (@(posedge clk) disable iff (rst)
      cancel_en |=> !(head_valid && head_line == $past(cancel_line)));

   // R11: the queue comes out of reset empty
   a_r11_reset_empty: assert property (@(posedge clk)
      $fell(rst) |-> !head_valid);
endmodule

// File: rtl/mb_prefetcher.sv
module mb_prefetcher #(
   parameter int LINE_W  = 16,
   parameter int ENTRIES = 8,
   parameter int DEPTH   = 4,
   parameter int THRESH  = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              dem_valid,
   output logic              dem_ready,
   input  logic [LINE_W-1:0] dem_line,
   output logic              pf_valid,
   input  logic              pf_ready,
   output logic [LINE_W-1:0] pf_line,
   output logic              pf_kind
);
   import mb_pf_pkg::*;
   localparam int TAG_W = LINE_W - MB_OFF_W;

   initial begin
      assert (LINE_W > MB_OFF_W) else $error("LINE_W too small");
   end

   logic                dem_acc, fire, pop;
   logic [TAG_W-1:0]    fire_tag;
   logic [MB_LINES-1:0] fire_mask;

   assign dem_ready = 1'b1;
   assign dem_acc   = dem_valid && dem_ready;
   assign pop       = pf_valid && pf_ready;
   assign pf_kind   = REQ_PREFETCH;

   mb_pf_table #(.TAG_W(TAG_W), .ENTRIES(ENTRIES), .THRESH(THRESH)) u_table (
      .clk       (clk),
      .rst       (rst),
      .dem_en    (dem_acc),
      .dem_tag   (dem_line[LINE_W-1:MB_OFF_W]),
      .dem_off   (dem_line[MB_OFF_W-1:0]),
      .fire      (fire),
      .fire_tag  (fire_tag),
      .fire_mask (fire_mask)
   );

   mb_pf_queue #(.LINE_W(LINE_W), .DEPTH(DEPTH)) u_queue (
      .clk         (clk),
      .rst         (rst),
      .pop         (pop),
      .cancel_en   (dem_acc),
      .cancel_line (dem_line),
      .push_mask   (fire ? fire_mask : '0),
      .push_tag    (fire_tag),
      .head_valid  (pf_valid),
      .head_line   (pf_line)
   );
endmodule

// File: tb/mb_prefetcher_test.sv
`timescale 1ns/1ps
module mb_prefetcher_test;
   localparam int LW = 16, NE = 8, QD = 4, TH = 2;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          dem_valid = 1'b0;
   logic [LW-1:0] dem_line = '0;
   logic          pf_ready = 1'b0;
   logic          dem_ready, pf_valid, pf_kind;
   logic [LW-1:0] pf_line;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   mb_prefetcher #(.LINE_W(LW), .ENTRIES(NE), .DEPTH(QD), .THRESH(TH)) uut (
      .clk(clk), .rst(rst), .dem_valid(dem_valid), .dem_ready(dem_ready),
      .dem_line(dem_line), .pf_valid(pf_valid), .pf_ready(pf_ready),
      .pf_line(pf_line), .pf_kind(pf_kind));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", req, act, exp);
      end
   endtask

   // behavioural reference model
   int      q[$];
   int      mtag [NE];
   bit [3:0] mmask[NE];
   bit      mv   [NE];
   bit      mdone[NE];
   int      mptr, t, o, h;
   bit [3:0] nm;

   always @(posedge clk) begin
      if (rst) begin
         q.delete();
         mptr = 0;
         for (int e = 0; e < NE; e++) begin mv[e] = 0; mdone[e] = 0; end
      end else begin
         if (q.size() > 0 && pf_ready) void'(q.pop_front());
         if (dem_valid) begin
            t = int'(dem_line) / 4;
            o = int'(dem_line) % 4;
            for (int i = q.size() - 1; i >= 0; i--)
               if (q[i] == int'(dem_line)) q.delete(i);
            h = -1;
            for (int e = 0; e < NE; e++) if (mv[e] && mtag[e] == t) h = e;
            if (h < 0) begin
               h = mptr; mptr = (mptr + 1) % NE;
               mv[h] = 1; mtag[h] = t; mmask[h] = 0; mdone[h] = 0;
            end
            nm = mmask[h] | (4'b1 << o);
            if (!mdone[h] && $countones(nm) >= TH) begin
               for (int j = 0; j < 4; j++)
                  if (!nm[j] && q.size() < QD) q.push_back(t * 4 + j);
               mdone[h] = 1;
            end
            mmask[h] = nm;
         end
      end
   end

   // compare with the model half a cycle after every edge (R6 ordering, R10 label)
   always @(negedge clk) begin
      if (!rst) begin
         chk(pf_valid == (q.size() > 0), "R6 model valid", int'(pf_valid), int'(q.size() > 0));
         if (q.size() > 0 && pf_valid) begin
            chk(int'(pf_line) == q[0], "R6 model line", int'(pf_line), q[0]);
            chk(pf_kind == 1'b1, "R10 kind", int'(pf_kind), 1);
         end
      end
   end

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic demand(input int l);
      dem_valid = 1'b1;
      dem_line  = LW'(l);
      @(negedge clk);
      dem_valid = 1'b0;
   endtask

   task automatic do_reset();
      rst = 1'b1;
      pf_ready = 1'b0;
      idle(2);
      rst = 1'b0;
      idle(1);
      chk(pf_valid == 1'b0, "R11 reset empty", int'(pf_valid), 0);
      chk(dem_ready == 1'b1, "R2 ready", int'(dem_ready), 1);
   endtask

   task automatic expect_head(input string req, input int l);
      chk(pf_valid == 1'b1, req, int'(pf_valid), 1);
      chk(int'(pf_line) == l, req, int'(pf_line), l);
   endtask

   task automatic expect_empty(input string req);
      chk(pf_valid == 1'b0, req, int'(pf_valid), 0);
   endtask

   initial begin
      #(8 * 150000);
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      @(negedge clk);
      do_reset();

      // R3: threshold fire, ascending order
      demand('h100);
      expect_empty("R3 one line");
      demand('h102);
      expect_head("R3 fire", 'h101);
      chk(pf_kind == 1'b1, "R10 kind", int'(pf_kind), 1);
      idle(2);
      expect_head("R6 stall hold", 'h101);
      pf_ready = 1'b1;
      idle(1);
      expect_head("R6 second", 'h103);
      idle(1);
      expect_empty("R6 drained");
      pf_ready = 1'b0;

      // R4: repeated line counts once
      demand('h200);
      demand('h200);
      expect_empty("R4 repeat");
      demand('h201);
      expect_head("R4 fire", 'h202);
      pf_ready = 1'b1; idle(2); pf_ready = 1'b0;
      expect_empty("R4 drained");

      // R5: no second fire; R1: block boundary
      demand('h203);
      expect_empty("R5 no refire");
      demand('h204);
      demand('h1FF);
      expect_empty("R1 boundary");
      demand('h205);
      expect_head("R1 aligned fire", 'h206);
      pf_ready = 1'b1; idle(2); pf_ready = 1'b0;

      // R8: cancel of a non-head and of the head
      demand('h300);
      demand('h301);
      demand('h303);
      expect_head("R8 cancel tail", 'h302);
      pf_ready = 1'b1; idle(1); pf_ready = 1'b0;
      expect_empty("R8 tail gone");
      demand('h310);
      demand('h311);
      demand('h312);
      expect_head("R8 cancel head", 'h313);
      pf_ready = 1'b1; idle(1); pf_ready = 1'b0;

      // R7: full queue discards
      do_reset();
      demand('h400); demand('h401);
      demand('h410); demand('h411);
      demand('h420); demand('h421);
      expect_head("R7 head kept", 'h402);
      pf_ready = 1'b1;
      idle(1); expect_head("R7 order", 'h403);
      idle(1); expect_head("R7 order", 'h412);
      idle(1); expect_head("R7 order", 'h413);
      idle(1); expect_empty("R7 dropped");
      pf_ready = 1'b0;
      demand('h422);
      expect_empty("R5 fired on drop");

      // R9: allocation-order replacement
      do_reset();
      for (int k = 0; k <= NE; k++) demand('h800 + 4 * k);
      demand('h801);
      expect_empty("R9 evicted");
      demand('h800 + 4 * NE + 1);
      expect_head("R9 resident", 'h800 + 4 * NE + 2);
      pf_ready = 1'b1; idle(2); pf_ready = 1'b0;

      // random traffic against the model
      do_reset();
      for (int c = 0; c < 3000; c++) begin
         dem_valid = ($urandom % 2) == 0;
         dem_line  = LW'('h1000 + ($urandom % 64));
         pf_ready  = ($urandom % 5) < 3;
         @(negedge clk);
      end
      dem_valid = 1'b0;
      pf_ready  = 1'b1;
      idle(QD + 2);
      expect_empty("R6 final drain");

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule